// File: doc/BRIEF.md
# Re-reference Interval Replacement Controller

This block keeps the replacement state of one set in a set-associative cache. Every way holds a 2-bit re-reference prediction: 0 says the line will be used again soon, 3 says it is not expected back. A hit request promotes the named way to the nearest prediction. A fill request searches for a way predicted distant, ages the whole set one step per cycle until such a way exists, then writes the chosen insertion value into it and reports that way as the victim.

The insertion value has three sources. A static mode always inserts at 2, which protects lines already in the set from a one-pass scan. A bimodal mode inserts at 3, except for one fill in every 32, which keeps a trickle of a thrashing working set. An external value can override both modes, so that a signature-based predictor can pick the insertion value for each fill. The prediction of every way is visible on an output bus, so the surrounding cache and the test can observe it.

Top module: `rrip_set_ctrl`

## Requirements
- R1: After a synchronous reset, every way holds prediction 3, `done` and `busy` are low and `victim_way` is 0.
- R2: `rrpv_out` bits [2i+1:2i] carry the current prediction of way i, where 0 is immediate, 1 intermediate, 2 far and 3 distant.
- R3: A fill chooses the lowest-numbered way whose prediction is 3.
- R4: An accepted hit (`req_fill` low) sets the prediction of `req_way` to 0, leaves every other way unchanged, and raises `done` for one cycle with `victim_way` equal to `req_way` on the cycle after acceptance.
- R5: When no way holds 3, every way's prediction rises by one, saturating at 3, one aging step per clock, until a way holds 3.
- R6: A fill needing k aging steps raises `done` k+1 cycles after acceptance (never later than 4); `busy` is high while aging and requests arriving then are ignored.
- R7: With `mode_bimodal` low and `ins_valid` low, a filled way receives prediction 2.
- R8: With `mode_bimodal` high and `ins_valid` low, a filled way receives 3, except when the number of fills accepted since reset (counting all modes) is a multiple of 32 at acceptance, when it receives 2.
- R9: With `ins_valid` high, a filled way receives `ins_value` regardless of mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_fill | input | 1 | 1 = fill (find victim and insert), 0 = hit |
| req_way | input | 4 | Way that was hit (hit requests only) |
| mode_bimodal | input | 1 | 0 = static insertion, 1 = bimodal insertion |
| ins_valid | input | 1 | External insertion value is valid |
| ins_value | input | 2 | External insertion value |
| done | output | 1 | One-cycle completion pulse |
| victim_way | output | 4 | Hit way or chosen victim, valid with `done` |
| busy | output | 1 | Aging in progress; requests ignored |
| rrpv_out | output | 32 | Predictions of all ways, 2 bits per way |

## Verification
A hit completes one clock after acceptance, so its pulse and the updated prediction are due on the falling edge after the accepting rising edge. A fill completes after one clock plus one per aging step; the bench's own model of the set counts those steps and predicts the exact edge, and the bench counts falling edges from acceptance until `done` and compares that count, the victim and the whole prediction bus against the model. Inputs change on falling edges only, and the request raised during aging is dropped one edge later, so that the result of the ignored hit is seen on the bus after the fill ends.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

  localparam int PRED_W = 2;

  localparam logic [PRED_W-1:0] PRED_NEAR = 2'd0;
  localparam logic [PRED_W-1:0] PRED_FAR  = 2'd2;
  localparam logic [PRED_W-1:0] PRED_DIST = 2'd3;

  typedef logic [PRED_W-1:0] pred_t;

  typedef enum logic [0:0] {
    ST_IDLE   = 1'b0,
    ST_SEARCH = 1'b1
  } ctrl_state_e;

endpackage

// File: rtl/rrip_victim_find.sv
module rrip_victim_find
  import rrip_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  pred_t [WAYS-1:0] pred_i,
  output logic             found_o,
  output logic [WAY_W-1:0] idx_o,
  output logic [WAYS-1:0]  distant_o
);

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign distant_o[g] = (pred_i[g] == PRED_DIST);
  end

  // lowest-numbered distant way wins: scan from the top down
  always_comb begin
    idx_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (distant_o[i]) idx_o = WAY_W'(i);
    end
  end

  assign found_o = |distant_o;

endmodule

// File: rtl/rrip_age.sv
module rrip_age
  import rrip_pkg::*;
#(
  parameter int WAYS = 16
) (
  input  pred_t [WAYS-1:0] pred_i,
  output pred_t [WAYS-1:0] aged_o
);

  for (genvar g = 0; g < WAYS; g++) begin : g_age
    assign aged_o[g] = (pred_i[g] == PRED_DIST) ? PRED_DIST : pred_i[g] + 2'd1;
  end

endmodule

// File: rtl/rrip_ins_sel.sv
module rrip_ins_sel
  import rrip_pkg::*;
#(
  parameter int BIP_PERIOD = 32,
  parameter int CNT_W      = (BIP_PERIOD > 1) ? $clog2(BIP_PERIOD) : 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  fill_take,
  input  logic  bimodal,
  input  logic  ext_valid,
  input  pred_t ext_value,
  output pred_t ins_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BIP_PERIOD - 1);

  logic [CNT_W-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt <= '0;
    end else if (fill_take) begin
      fill_cnt <= (fill_cnt == CNT_LAST) ? '0 : fill_cnt + 1'b1;
    end
  end

  always_comb begin
    if (ext_valid)        ins_o = ext_value;
    else if (!bimodal)    ins_o = PRED_FAR;
    else if (fill_cnt == '0) ins_o = PRED_FAR;
    else                  ins_o = PRED_DIST;
  end

  AST_BIP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (fill_take && fill_cnt == CNT_LAST) |=> (fill_cnt == '0)); // R8

endmodule

// File: rtl/rrip_set_ctrl.sv
module rrip_set_ctrl
  import rrip_pkg::*;
#(
  parameter int WAYS       = 16,
  parameter int BIP_PERIOD = 32,
  parameter int WAY_W      = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_fill,
  input  logic [WAY_W-1:0]    req_way,
  input  logic                mode_bimodal,
  input  logic                ins_valid,
  input  logic [1:0]          ins_value,
  output logic                done,
  output logic [WAY_W-1:0]    victim_way,
  output logic                busy,
  output logic [2*WAYS-1:0]   rrpv_out
);

  localparam int LAT_W = 2;

  ctrl_state_e      state_q;
  pred_t [WAYS-1:0] pred_q;
  pred_t [WAYS-1:0] pred_aged;
  pred_t            ins_sel;
  pred_t            ins_q;
  pred_t            ins_now;
  logic             found;
  logic [WAY_W-1:0] vidx;
  logic [WAYS-1:0]  distant;
  logic             accept;
  logic             take_fill;
  logic             look;
  logic             done_fill_q;
  logic [LAT_W-1:0] lat_q;

  assign accept    = req_valid && (state_q == ST_IDLE);
  assign take_fill = accept && req_fill;
  assign look      = take_fill || (state_q == ST_SEARCH);
  assign ins_now   = (state_q == ST_IDLE) ? ins_sel : ins_q;

  rrip_victim_find #(.WAYS(WAYS), .WAY_W(WAY_W)) u_find (
    .pred_i    (pred_q),
    .found_o   (found),
    .idx_o     (vidx),
    .distant_o (distant)
  );

  rrip_age #(.WAYS(WAYS)) u_age (
    .pred_i (pred_q),
    .aged_o (pred_aged)
  );

  rrip_ins_sel #(.BIP_PERIOD(BIP_PERIOD)) u_ins (
    .clk       (clk),
    .rst       (rst),
    .fill_take (take_fill),
    .bimodal   (mode_bimodal),
    .ext_valid (ins_valid),
    .ext_value (ins_value),
    .ins_o     (ins_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q      <= {WAYS{PRED_DIST}};
      state_q     <= ST_IDLE;
      done        <= 1'b0;
      victim_way  <= '0;
      ins_q       <= PRED_FAR;
      done_fill_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (take_fill) ins_q <= ins_sel;
      if (accept && !req_fill) begin
        pred_q[req_way] <= PRED_NEAR;
        done            <= 1'b1;
        victim_way      <= req_way;
        done_fill_q     <= 1'b0;
      end else if (look) begin
        if (found) begin
          pred_q[vidx] <= ins_now;
          done         <= 1'b1;
          victim_way   <= vidx;
          done_fill_q  <= 1'b1;
          state_q      <= ST_IDLE;
        end else begin
          pred_q  <= pred_aged;
          state_q <= ST_SEARCH;
        end
      end
    end
  end

  // aging-step counter kept only to bound the search in an assertion
  always_ff @(posedge clk) begin
    if (rst || state_q == ST_IDLE) lat_q <= '0;
    else if (lat_q != '1)          lat_q <= lat_q + 1'b1;
  end

  assign busy     = (state_q == ST_SEARCH);
  assign rrpv_out = pred_q;

  AST_HIT_PROMOTE: assert property (@(posedge clk) disable iff (rst)
    (accept && !req_fill) |=> (pred_q[$past(req_way)] == PRED_NEAR)); // R4

  AST_LOWEST_VICTIM: assert property (@(posedge clk) disable iff (rst)
    (look && found) |-> ((distant & ((WAYS'(1) << vidx) - WAYS'(1))) == '0)); // R3

  AST_SEARCH_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEARCH) |-> (lat_q < 2'd3)); // R6

  AST_INSERT_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    (done && done_fill_q) |-> (pred_q[victim_way] == ins_q)); // R9

  AST_NO_DIST_AGES: assert property (@(posedge clk) disable iff (rst)
    (look && !found) |=> (busy && !done)); // R5

endmodule

// File: tb/rrip_set_ctrl_bench.sv
module rrip_set_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int NVEC = 24;

  // {fill, way, bimodal, ext_valid, ext_value}
  localparam logic [8:0] VEC [NVEC] = '{
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b0, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b1, 2'd0},
    {1'b1, 4'd0,  1'b1, 1'b1, 2'd1},
    {1'b1, 4'd0,  1'b1, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b1, 2'd2},
    {1'b1, 4'd0,  1'b0, 1'b0, 2'd0},
    {1'b0, 4'd3,  1'b0, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b1, 1'b0, 2'd0},
    {1'b0, 4'd15, 1'b1, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b1, 1'b0, 2'd0},
    {1'b1, 4'd0,  1'b0, 1'b1, 2'd3}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_fill = 1'b0;
  logic [3:0]  req_way = '0;
  logic        mode_bimodal = 1'b0;
  logic        ins_valid = 1'b0;
  logic [1:0]  ins_value = '0;
  logic        done;
  logic [3:0]  victim_way;
  logic        busy;
  logic [31:0] rrpv_out;

  int errors = 0;
  int checks = 0;
  int m [NW];
  int fillcnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rrip_set_ctrl u_rrip_set_ctrl (
    .clk (clk), .rst (rst), .req_valid (req_valid), .req_fill (req_fill),
    .req_way (req_way), .mode_bimodal (mode_bimodal), .ins_valid (ins_valid),
    .ins_value (ins_value), .done (done), .victim_way (victim_way),
    .busy (busy), .rrpv_out (rrpv_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // model of one request; returns expected victim and latency in cycles
  task automatic model_step(input bit fill, input int way, input bit bim,
                            input bit xv, input int xval,
                            output int ev, output int el, output int ins);
    int k;
    int v;
    ins = 0;
    if (!fill) begin
      m[way] = 0; ev = way; el = 1;
    end else begin
      if (xv)        ins = xval;           // R9
      else if (!bim) ins = 2;              // R7
      else           ins = (fillcnt % 32 == 0) ? 2 : 3; // R8
      fillcnt++;
      k = 0;
      v = -1;
      while (v < 0) begin
        for (int i = NW - 1; i >= 0; i--) if (m[i] == 3) v = i;
        if (v < 0) begin
          for (int i = 0; i < NW; i++) if (m[i] < 3) m[i]++;
          k++;
        end
      end
      m[v] = ins; ev = v; el = k + 1;
    end
  endtask

  task automatic check_state(input string req);
    int bad;
    int act;
    bad = -1;
    for (int i = 0; i < NW; i++) if (bad < 0 && int'(rrpv_out[2*i +: 2]) != m[i]) bad = i;
    act = (bad < 0) ? 0 : int'(rrpv_out[2*bad +: 2]);
    chk(bad < 0, req, act, (bad < 0) ? 0 : m[bad]);
  endtask

  // drive one request on a falling edge; count falling edges until done
  task automatic run_req(input bit fill, input int way, input bit bim,
                         input bit xv, input int xval,
                         output int lat, output int vic);
    @(negedge clk);
    req_valid = 1'b1; req_fill = fill; req_way = 4'(way);
    mode_bimodal = bim; ins_valid = xv; ins_value = 2'(xval);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    vic = int'(victim_way);
  endtask

  task automatic do_vec(input bit fill, input int way, input bit bim,
                        input bit xv, input int xval, input string tag);
    int lat, vic, ev, el, ins;
    run_req(fill, way, bim, xv, xval, lat, vic);
    model_step(fill, way, bim, xv, xval, ev, el, ins);
    chk(vic == ev, {tag, " victim (R3/R4)"}, vic, ev);
    chk(lat == el, {tag, " latency (R5/R6)"}, lat, el);
    check_state({tag, " state (R2/R5)"});
    if (fill) chk(int'(rrpv_out[2*ev +: 2]) == ins, {tag, " inserted value (R7/R8/R9)"},
                  int'(rrpv_out[2*ev +: 2]), ins);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    int vic;
    int ev;
    int el;
    int ins;
    for (int i = 0; i < NW; i++) m[i] = 3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk(rrpv_out == '1, "R1 predictions", int'(rrpv_out[15:0]), 16'hffff);
    chk(!done, "R1 done", int'(done), 0);
    chk(!busy, "R1 busy", int'(busy), 0);
    chk(victim_way == '0, "R1 victim", int'(victim_way), 0);

    // table walk
    for (int n = 0; n < NVEC; n++) begin
      do_vec(VEC[n][8], int'(VEC[n][7:4]), VEC[n][3], VEC[n][2], int'(VEC[n][1:0]),
             $sformatf("vec%0d", n));
    end

    // R4: hit every way to reach an all-immediate set
    for (int w = 0; w < NW; w++) do_vec(1'b0, w, 1'b0, 1'b0, 0, "R4 hit sweep");

    // R6: full search (3 aging steps) with a hit raised while busy
    @(negedge clk);
    req_valid = 1'b1; req_fill = 1'b1; mode_bimodal = 1'b0; ins_valid = 1'b0;
    @(negedge clk);
    chk(busy, "R6 busy while aging", int'(busy), 1);
    req_fill = 1'b0; req_way = 4'd5;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 2;
    while (!done && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    model_step(1'b1, 0, 1'b0, 1'b0, 0, ev, el, ins);
    chk(lat == 4 && el == 4, "R6 worst-case latency", lat, 4);
    chk(int'(victim_way) == ev, "R3 victim after full aging", int'(victim_way), ev);
    chk(int'(rrpv_out[11:10]) == m[5], "R6 hit ignored while busy", int'(rrpv_out[11:10]), m[5]);
    check_state("R5 state after full aging");

    // R8: bimodal run across a period boundary
    for (int n = 0; n < 34; n++) do_vec(1'b1, 0, 1'b1, 1'b0, 0, "R8 bimodal");

    // R9: override in bimodal and static modes
    do_vec(1'b1, 0, 1'b1, 1'b1, 0, "R9 override bimodal");
    do_vec(1'b1, 0, 1'b0, 1'b1, 1, "R9 override static");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule